// File: doc/BRIEF.md
# Byte-Addressed Two-Wire Memory Slave

This block is a two-wire serial bus slave with a 512-byte array behind it. It runs from a system clock that oversamples the already synchronized SCL and SDA inputs. It pulls SDA low through an open-drain enable and never holds SCL. A nine-bit address latch serves reads and writes alike. The top address bit arrives inside the slave address byte, and the low eight bits arrive in a word-address byte that only writes carry. There is no write delay. Each byte lands in the array at the eighth data clock, before its acknowledge, so the next transaction can start at once.

To set a read address, the host writes a slave address and a word address, then either stops or issues a repeated START followed by a read slave address. After that, reads and writes both stream through the array and wrap at the end. A write-protect input blocks array updates.

Top module: `serial_nvram_slave`

## Requirements
- R1: The array holds 512 bytes addressed by 9 bits. The address latch steps from 0x1FF to 0x000 on both reads and writes, and a transfer may run for any number of bytes.
- R2: The slave address byte is sent MSB first. It holds type code 1010 in bits 7..4 and two select bits in bits 3..2, where bit 3 must equal dev_sel[1] and bit 2 must equal dev_sel[0]. Bit 1 is address bit 8, which is loaded into the latch. Bit 0 is 1 for read and 0 for write. On a match the slave pulls SDA low during the ninth clock.
- R3: If the type code or the select bits do not match, the slave gives no acknowledge and keeps SDA released through any later bytes until the next START.
- R4: A write is the slave address, then one word-address byte that loads latch bits 7..0, then any number of data bytes. The slave acknowledges each data byte and stores each one at successive addresses.
- R5: A read carries no word address and begins at the current latch value. The slave drives each byte MSB first. A low acknowledge from the master continues with the next byte. A high acknowledge ends the read, and SDA stays released.
- R6: The latch advances once per transferred data byte, so a later read or write without a word address continues at the next address.
- R7: A START or STOP that arrives before the eighth data bit leaves both the array and the latch as they were.
- R8: While wp_i is high, the slave still acknowledges the word address, but data bytes get no acknowledge, the array is not changed, and the latch does not advance.
- R9: The slave has no busy period: a slave address sent right after a completed write is acknowledged.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts slave-address decoding, a STOP releases SDA, and the slave changes SDA only while SCL is low.
- R11: After reset, SDA is released, the latch holds 0x000 and the array reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock level |
| sda_i | input | 1 | Synchronized serial data line level |
| dev_sel | input | 2 | Device-select straps compared with slave address bits 3..2 |
| wp_i | input | 1 | Write protect, active high |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
A corrupted address latch does not show up until the next data byte leaves the slave. It then appears as a wrong byte on the first read that has no word address, or as a misplaced byte when that location is read back. The bench therefore follows every stream, abort and write-protect case with a current-address read. A decoder that matches the wrong bits, or a controller that drives the bus in the wrong state, is seen at once as an acknowledge bit with the wrong level within nine SCL periods. An SDA change while SCL is high would look like a false START or STOP in that same bit time.

// File: rtl/nvram_pkg.sv
package nvram_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    typedef struct packed {
        logic [3:0] kind;
        logic [1:0] sel;
        logic       page;
        logic       rd;
    } dev_byte_t;

    function automatic logic dev_hit(input dev_byte_t b, input logic [1:0] strap);
        return (b.kind == DEV_TYPE) && (b.sel == strap);
    endfunction

endpackage

// File: rtl/nvram_bus_cond.sv
module nvram_bus_cond
    import nvram_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.start = scl_q & scl_i & sda_q & ~sda_i;
        evt.stop  = scl_q & scl_i & ~sda_q & sda_i;
        evt.rise  = ~scl_q & scl_i;
        evt.fall  = scl_q & ~scl_i;
    end

endmodule

// File: rtl/nvram_byte_store.sv
module nvram_byte_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/nvram_proto_fsm.sv
module nvram_proto_fsm
    import nvram_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              sda_i,
    input  logic [1:0]        dev_sel,
    input  logic              wp_i,
    input  logic [DATA_W-1:0] rdata,
    output logic              sda_oe,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] addr,
    output bus_state_e        state
);

    localparam int unsigned BCW = $clog2(DATA_W + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);
    localparam logic [BCW-1:0] FULL     = BCW'(DATA_W);
    localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);

    logic [BCW-1:0]    bitcnt;
    logic [DATA_W-1:0] shreg;
    logic              rd_q;
    logic              ack_q;

    // commit point: eighth rising SCL edge of a data byte
    always_comb begin
        mem_we    = (state == ST_WDATA) && evt.rise && (bitcnt == LAST_BIT) && !wp_i;
        mem_wdata = {shreg[DATA_W-2:0], sda_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            addr   <= '0;
            rd_q   <= 1'b0;
            ack_q  <= 1'b0;
            sda_oe <= 1'b0;
        end else if (evt.start) begin
            state  <= ST_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_DEV: begin
                    if (evt.rise) begin
                        shreg  <= {shreg[DATA_W-2:0], sda_i};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (evt.fall && bitcnt == FULL) begin
                        if (dev_hit(dev_byte_t'(shreg), dev_sel)) begin
                            sda_oe         <= 1'b1;
                            addr[ADDR_W-1] <= shreg[1];
                            rd_q           <= shreg[0];
                            state          <= ST_DEV_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (evt.fall) begin
                        if (rd_q) begin
                            shreg  <= rdata << 1;
                            sda_oe <= ~rdata[DATA_W-1];
                            bitcnt <= BCW'(1);
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WADDR;
                        end
                    end
                end
                ST_WADDR: begin
                    if (evt.rise) begin
                        shreg  <= {shreg[DATA_W-2:0], sda_i};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (evt.fall && bitcnt == FULL) begin
                        addr[ADDR_W-2:0] <= shreg;
                        sda_oe           <= 1'b1;
                        state            <= ST_WADDR_ACK;
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (evt.fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (evt.rise) begin
                        shreg  <= {shreg[DATA_W-2:0], sda_i};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == LAST_BIT) begin
                            ack_q <= !wp_i;
                        end
                        if (mem_we) begin
                            addr <= addr + ONE;
                        end
                    end else if (evt.fall && bitcnt == FULL) begin
                        sda_oe <= ack_q;
                        state  <= ST_WDATA_ACK;
                    end
                end
                ST_RDATA: begin
                    if (evt.fall) begin
                        if (bitcnt == FULL) begin
                            sda_oe <= 1'b0;
                            addr   <= addr + ONE;
                            state  <= ST_RDATA_ACK;
                        end else begin
                            sda_oe <= ~shreg[DATA_W-1];
                            shreg  <= shreg << 1;
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (evt.rise) begin
                        ack_q <= ~sda_i;
                    end else if (evt.fall) begin
                        if (ack_q) begin
                            shreg  <= rdata << 1;
                            sda_oe <= ~rdata[DATA_W-1];
                            bitcnt <= BCW'(1);
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/serial_nvram_slave.sv
module serial_nvram_slave
    import nvram_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] dev_sel,
    input  logic       wp_i,
    output logic       sda_oe
);

    localparam int unsigned ADDR_W = DATA_W + 1;

    bus_evt_t          evt;
    logic              start_det;
    logic              stop_det;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic [ADDR_W-1:0] cur_addr;
    bus_state_e        fsm_state;

    nvram_bus_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    assign start_det = evt.start;
    assign stop_det  = evt.stop;

    nvram_proto_fsm #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .sda_i     (sda_i),
        .dev_sel   (dev_sel),
        .wp_i      (wp_i),
        .rdata     (mem_rdata),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .addr      (cur_addr),
        .state     (fsm_state)
    );

    nvram_byte_store #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (cur_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/nvram_slave_chk.sv
module nvram_slave_chk
    import nvram_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              wp_i,
    input logic              sda_oe,
    input logic              start_det,
    input logic              stop_det,
    input logic              mem_we,
    input logic [ADDR_W-1:0] cur_addr,
    input bus_state_e        fsm_state
);

    assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_i));

    assert_stop_releases_R10: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (!sda_oe && fsm_state == ST_IDLE));

    assert_start_decodes_R10: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (fsm_state == ST_DEV));

    assert_addr_step_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (cur_addr == $past(cur_addr) + ADDR_W'(1)));

    assert_protect_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        wp_i |-> !mem_we);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_IDLE) |-> !sda_oe);

endmodule

bind serial_nvram_slave nvram_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .wp_i      (wp_i),
    .sda_oe    (sda_oe),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mem_we    (mem_we),
    .cur_addr  (cur_addr),
    .fsm_state (fsm_state)
);

// File: tb/tb_serial_nvram_slave.sv
module tb_serial_nvram_slave;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] STRAP = 2'b10;
    localparam int NVEC = 6;
    // {9-bit address, data byte}
    localparam logic [16:0] VEC [NVEC] = '{
        {9'h005, 8'h5E}, {9'h07F, 8'h81}, {9'h100, 8'hC4},
        {9'h1A5, 8'h2B}, {9'h0AA, 8'h55}, {9'h1FE, 8'hE7}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   n_checks = 0;
    int   n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    serial_nvram_slave dut (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (m_scl),
        .sda_i   (sda_line),
        .dev_sel (STRAP),
        .wp_i    (wp),
        .sda_oe  (sda_oe)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic q();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic page, input logic rd);
        return {4'b1010, STRAP, page, rd};
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; q(); m_scl = 1'b1; q();
        ack = ~sda_line;
        q(); m_scl = 1'b0; q();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q(); m_scl = 1'b1; q(); b[i] = sda_line; q(); m_scl = 1'b0;
        end
        q(); m_sda = ~ack; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q(); m_sda = 1'b1;
    endtask

    task automatic write_seq(input logic [8:0] a, input logic [7:0] d0, input logic [7:0] d1,
                             input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(dev(a[8], 1'b0), ack); check({tag, " dev ack"}, 16'(ack), 16'd1);
        send_byte(a[7:0], ack);          check({tag, " word ack"}, 16'(ack), 16'd1);
        send_byte(d0, ack);              check({tag, " data ack"}, 16'(ack), 16'd1);
        if (n > 1) begin
            send_byte(d1, ack);          check({tag, " data2 ack"}, 16'(ack), 16'd1);
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [8:0] a, output logic [7:0] b);
        logic ack;
        bus_start();
        send_byte(dev(a[8], 1'b0), ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(dev(a[8], 1'b1), ack);
        recv_byte(b, 1'b0);
        bus_stop();
    endtask

    task automatic cur_read(input logic page, output logic [7:0] b, output logic ack);
        bus_start();
        send_byte(dev(page, 1'b1), ack);
        recv_byte(b, 1'b0);
        bus_stop();
    endtask

    task automatic run_all();
        logic [7:0] b, b2;
        logic ack;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        q();
        // R11 reset state
        check("R11 sda released", 16'(sda_oe), 16'd0);
        cur_read(1'b0, b, ack);
        check("R2 read addr ack", 16'(ack), 16'd1);
        check("R11 zero at 0x000", 16'(b), 16'h00);

        // vector walk: R4 write, R5/R10 random read via repeated START
        for (int i = 0; i < NVEC; i++) begin
            write_seq(VEC[i][16:8], VEC[i][7:0], 8'h00, 1, "R4");
        end
        for (int i = 0; i < NVEC; i++) begin
            rand_read(VEC[i][16:8], b);
            check("R5 R10 readback", 16'(b), 16'(VEC[i][7:0]));
        end

        // R6 latch continues after a write
        write_seq(9'h122, 8'h5A, 8'h00, 1, "R6 prep");
        write_seq(9'h120, 8'h11, 8'h22, 2, "R6 stream");
        cur_read(1'b1, b, ack);
        check("R6 continue at 0x122", 16'(b), 16'h5A);

        // R1 wrap on write and read
        write_seq(9'h1FF, 8'hA1, 8'hB2, 2, "R1");
        bus_start();
        send_byte(dev(1'b1, 1'b0), ack);
        send_byte(8'hFF, ack);
        bus_start();
        send_byte(dev(1'b1, 1'b1), ack);
        recv_byte(b, 1'b1);
        recv_byte(b2, 1'b0);
        // R5 NACK releases SDA
        check("R5 released after nack", 16'(sda_oe), 16'd0);
        bus_stop();
        check("R1 byte at 0x1FF", 16'(b), 16'hA1);
        check("R1 wrapped byte at 0x000", 16'(b2), 16'hB2);

        // R3 mismatched select bits and type code
        bus_start();
        send_byte({4'b1010, ~STRAP, 2'b00}, ack);
        check("R3 wrong select nack", 16'(ack), 16'd0);
        send_byte(8'h00, ack);
        check("R3 stays released", 16'(ack), 16'd0);
        bus_stop();
        bus_start();
        send_byte({4'b0110, STRAP, 2'b00}, ack);
        check("R3 wrong type nack", 16'(ack), 16'd0);
        bus_stop();

        // R7 abort by STOP and by START before the eighth bit
        write_seq(9'h030, 8'hC3, 8'h00, 1, "R7 prep");
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack);
        send_byte(8'h30, ack);
        send_bits(8'h00, 5);
        bus_stop();
        cur_read(1'b0, b, ack);
        check("R7 stop abort keeps byte and addr", 16'(b), 16'hC3);
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack);
        send_byte(8'h30, ack);
        send_bits(8'hFF, 6);
        bus_start();
        send_byte(dev(1'b0, 1'b1), ack);
        recv_byte(b, 1'b0);
        bus_stop();
        check("R7 start abort keeps byte and addr", 16'(b), 16'hC3);

        // R8 write protect
        wp = 1'b1;
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack);
        send_byte(8'h30, ack);
        check("R8 word addr acked", 16'(ack), 16'd1);
        send_byte(8'h77, ack);
        check("R8 data nacked", 16'(ack), 16'd0);
        send_byte(8'h88, ack);
        check("R8 second data nacked", 16'(ack), 16'd0);
        bus_stop();
        wp = 1'b0;
        cur_read(1'b0, b, ack);
        check("R8 array and addr unchanged", 16'(b), 16'hC3);

        // R9 addressing right after a write
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack);
        send_byte(8'h40, ack);
        send_byte(8'h9D, ack);
        bus_stop();
        bus_start();
        send_byte(dev(1'b0, 1'b1), ack);
        check("R9 no busy ack", 16'(ack), 16'd1);
        recv_byte(b, 1'b0);
        bus_stop();
        rand_read(9'h040, b);
        check("R9 byte committed", 16'(b), 16'h9D);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule